// File: doc/BRIEF.md
# Interrupt Pending State Bank

This block holds the pending state of one bank of interrupt lines (32 by default). Each line can be set to edge or level sensing. An edge line latches pending on a rising input or on a set-pending write. It stays pending until that interrupt is activated or a clear-pending write arrives.

A level line latches only software set-pending writes. Its visible pending value is that latch combined with the live input level, so clearing the latch cannot hide an input that is still asserted.

The visible pending vector feeds arbitration and delivery logic elsewhere. The raw latch vector and a debug port let save and restore software read and write the latch itself, separate from the visible value. The debug port offers two views. The set view reaches the latch. The clear view reads as zero and ignores writes.

Bit n of every vector stands for interrupt number `BANK_BASE + n`, and `BANK_BASE` is a multiple of 32. Lines numbered at or above `NUM_IRQS` do not exist. Lines numbered below `RSVD_LINES` take no input from the line-level port.

Top module: `irq_pend_bank`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `pend_o`, `raw_o` and `dbg_rdata_o` are all zero.
- R2: For a line with `trig_edge_i[n]=1`, a 0-to-1 change of `line_i[n]` between two consecutive cycles sets `raw_o[n]` and `pend_o[n]` one clock later. The bit stays set after the line falls. A line held high produces no further edge.
- R3: For an edge line, a clear-pending write (`clr_stb_i=1` with `clr_mask_i[n]=1`) or an activation pulse `act_i[n]` clears the pending bit one clock later.
- R4: For a line of either kind, a set-pending write (`set_stb_i=1` with `set_mask_i[n]=1`) sets `raw_o[n]` one clock later. If set-pending and clear-pending (or activation) hit the same bit in the same cycle, the set wins.
- R5: For a line with `trig_edge_i[n]=0`, `pend_o[n]` equals `raw_o[n]` OR the `line_i[n]` level of the previous cycle. A high level alone never sets `raw_o[n]`.
- R6: For a level line, clear-pending or activation clears `raw_o[n]`, but `pend_o[n]` stays 1 while the input is high. Once the input falls, `pend_o[n]` is 0 unless a set-pending write has left the latch set.
- R7: The debug port has two views, selected by `dbg_view_i`: 0 is the latch view and 1 is the clear view. A write (`dbg_wr_i`) in the latch view replaces the whole latch with `dbg_wdata_i`, one clock later, and takes priority over every other source in that cycle. A read (`dbg_rd_i`) in the latch view returns the latch as it was before that cycle's update, on `dbg_rdata_o` one clock later. In the clear view, reads return 0 and writes change nothing.
- R8: Bits whose interrupt number `BANK_BASE+n` is at or above `NUM_IRQS` (bits 28..31 by default) always read 0 on every output and ignore every input.
- R9: Bits whose interrupt number is below `RSVD_LINES` (bits 0..15 by default) ignore `line_i`, but they still accept set-pending, clear-pending, activation and debug writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_edge_i | input | 32 | Per-line sensing: 1 for edge, 0 for level |
| line_i | input | 32 | Raw, already synchronised line levels |
| set_stb_i | input | 1 | Set-pending write strobe |
| set_mask_i | input | 32 | Bits to mark pending |
| clr_stb_i | input | 1 | Clear-pending write strobe |
| clr_mask_i | input | 32 | Bits whose latch is cleared |
| act_i | input | 32 | Per-line activation pulses |
| dbg_wr_i | input | 1 | Debug write strobe |
| dbg_rd_i | input | 1 | Debug read strobe |
| dbg_view_i | input | 1 | Debug view: 0 latch, 1 clear view |
| dbg_wdata_i | input | 32 | Debug write data |
| pend_o | output | 32 | Visible pending vector |
| raw_o | output | 32 | Raw latch vector |
| dbg_rdata_o | output | 32 | Debug read data |

## Verification
Edge lines are driven with single pulses, with levels held across a clear, and with activation pulses. These cases separate true 0-to-1 detection from simple level latching. Level lines get set-pending writes and clears, both with the input held high and with the input falling. These cases show whether the visible value is the OR of latch and level and whether raw and visible are kept apart. Writes that hit the same bit in one cycle, debug traffic in both views, and stimulus on the reserved and non-existent bits check priority and masking. A behavioural scoreboard model predicts every output for every cycle.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  typedef enum logic {
    VIEW_LATCH = 1'b0,
    VIEW_CLEAR = 1'b1
  } dbg_view_e;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] line_i,
  input  logic [W-1:0] edge_cfg_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= line_i;
  end

  assign rise_o = edge_cfg_i & line_i & ~prev_q;

  // R2: a rise is only reported when the line was low in the previous cycle
  p_rise_needs_low_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((rise_o & $past(line_i)) == '0));
endmodule

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] valid_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] rise_i,
  input  logic         dbg_we_i,
  input  logic [W-1:0] dbg_wdata_i,
  output logic [W-1:0] lat_d_o,
  output logic [W-1:0] lat_q_o
);
  logic [W-1:0] lat_q;
  logic [W-1:0] lat_d;

  always_comb begin
    if (dbg_we_i) lat_d = dbg_wdata_i & valid_i;
    else          lat_d = ((lat_q & ~clr_i) | set_i | rise_i) & valid_i;
  end

  always_ff @(posedge clk) begin
    if (rst) lat_q <= '0;
    else     lat_q <= lat_d;
  end

  assign lat_d_o = lat_d;
  assign lat_q_o = lat_q;

  // R4: a set-pending bit is latched even if clear or activation hit it too
  p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
    !dbg_we_i |=> ((lat_q & $past(set_i & valid_i)) == $past(set_i & valid_i)));

  // R3: a cleared bit with no set or rise in the same cycle is dropped
  p_clear_drops_r3: assert property (@(posedge clk) disable iff (rst)
    !dbg_we_i |=> ((lat_q & $past(clr_i & ~set_i & ~rise_i)) == '0));

  // R8: non-existent lines never latch
  p_invalid_latch_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((lat_q & ~$past(valid_i)) == '0));
endmodule

// File: rtl/irq_pend_view.sv
module irq_pend_view #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lat_d_i,
  input  logic [W-1:0] lat_q_i,
  input  logic [W-1:0] lvl_line_i,
  input  logic         dbg_rd_i,
  input  logic         dbg_view_clr_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] dbg_rdata_o
);
  logic [W-1:0] pend_q;
  logic [W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      rdata_q <= '0;
    end else begin
      pend_q  <= lat_d_i | lvl_line_i;
      rdata_q <= (dbg_rd_i && !dbg_view_clr_i) ? lat_q_i : '0;
    end
  end

  assign pend_o      = pend_q;
  assign dbg_rdata_o = rdata_q;

  // R5: a level line held high is visible as pending one cycle later
  p_level_visible_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q & $past(lvl_line_i)) == $past(lvl_line_i)));

  // R7: reads through the clear view return zero
  p_clear_view_raz_r7: assert property (@(posedge clk) disable iff (rst)
    (dbg_rd_i && dbg_view_clr_i) |=> (rdata_q == '0));
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
  import irq_pend_pkg::*;
#(
  parameter int W          = 32,
  parameter int BANK_BASE  = 0,
  parameter int NUM_IRQS   = 28,
  parameter int RSVD_LINES = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] trig_edge_i,
  input  logic [W-1:0] line_i,
  input  logic         set_stb_i,
  input  logic [W-1:0] set_mask_i,
  input  logic         clr_stb_i,
  input  logic [W-1:0] clr_mask_i,
  input  logic [W-1:0] act_i,
  input  logic         dbg_wr_i,
  input  logic         dbg_rd_i,
  input  logic         dbg_view_i,
  input  logic [W-1:0] dbg_wdata_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] dbg_rdata_o
);
  localparam int BASE_ALIGN = 32;

  initial begin
    a_base_aligned: assert (BANK_BASE % BASE_ALIGN == 0)
      else $error("bank base not aligned");
  end

  logic [W-1:0] valid_m;
  logic [W-1:0] lvl_ok_m;

  for (genvar n = 0; n < W; n++) begin : g_mask
    assign valid_m[n]  = (BANK_BASE + n) < NUM_IRQS;
    assign lvl_ok_m[n] = ((BANK_BASE + n) < NUM_IRQS) && ((BANK_BASE + n) >= RSVD_LINES);
  end

  logic [W-1:0] line_eff;
  logic [W-1:0] set_v;
  logic [W-1:0] clr_v;
  logic [W-1:0] rise;
  logic [W-1:0] lat_d;
  logic [W-1:0] lat_q;
  logic         view_clr;
  logic         dbg_we;

  assign line_eff = line_i & lvl_ok_m;
  assign set_v    = (set_stb_i ? set_mask_i : '0) & valid_m;
  assign clr_v    = ((clr_stb_i ? clr_mask_i : '0) | act_i) & valid_m;
  assign view_clr = (dbg_view_e'(dbg_view_i) == VIEW_CLEAR);
  assign dbg_we   = dbg_wr_i && !view_clr;

  irq_edge_det #(.W(W)) u_edge (
    .clk        (clk),
    .rst        (rst),
    .line_i     (line_eff),
    .edge_cfg_i (trig_edge_i),
    .rise_o     (rise)
  );

  irq_pend_latch #(.W(W)) u_latch (
    .clk         (clk),
    .rst         (rst),
    .valid_i     (valid_m),
    .set_i       (set_v),
    .clr_i       (clr_v),
    .rise_i      (rise),
    .dbg_we_i    (dbg_we),
    .dbg_wdata_i (dbg_wdata_i),
    .lat_d_o     (lat_d),
    .lat_q_o     (lat_q)
  );

  irq_pend_view #(.W(W)) u_view (
    .clk            (clk),
    .rst            (rst),
    .lat_d_i        (lat_d),
    .lat_q_i        (lat_q),
    .lvl_line_i     (line_eff & ~trig_edge_i),
    .dbg_rd_i       (dbg_rd_i),
    .dbg_view_clr_i (view_clr),
    .pend_o         (pend_o),
    .dbg_rdata_o    (dbg_rdata_o)
  );

  assign raw_o = lat_q;

  // R8: non-existent lines are zero on the visible vector
  p_invalid_zero_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_o & ~valid_m) == '0));

  // R9: reserved low lines never become pending through the line input alone
  p_rsvd_no_line_r9: assert property (@(posedge clk) disable iff (rst)
    (!set_stb_i && !dbg_wr_i && ((raw_o & ~lvl_ok_m) == '0))
      |=> ((raw_o & ~lvl_ok_m) == '0));
endmodule

// File: tb/irq_pend_bank_tb.sv
`timescale 1ns/1ps
module irq_pend_bank_tb;
  localparam int W = 32;
  // bits 28..31 do not exist; bits 0..15 ignore the line input
  localparam logic [W-1:0] VALID  = 32'h0FFF_FFFF;
  localparam logic [W-1:0] LVL_OK = 32'h0FFF_0000;
  localparam logic [W-1:0] EDGE   = 32'h003F_FFFF; // bits 0..21 edge, 22..27 level

  logic clk = 1'b0;
  logic rst;
  logic [W-1:0] trig_edge_i, line_i, set_mask_i, clr_mask_i, act_i, dbg_wdata_i;
  logic set_stb_i, clr_stb_i, dbg_wr_i, dbg_rd_i, dbg_view_i;
  logic [W-1:0] pend_o, raw_o, dbg_rdata_o;

  always #2.5 clk = ~clk;

  irq_pend_bank u_dut (
    .clk(clk), .rst(rst), .trig_edge_i(trig_edge_i), .line_i(line_i),
    .set_stb_i(set_stb_i), .set_mask_i(set_mask_i),
    .clr_stb_i(clr_stb_i), .clr_mask_i(clr_mask_i), .act_i(act_i),
    .dbg_wr_i(dbg_wr_i), .dbg_rd_i(dbg_rd_i), .dbg_view_i(dbg_view_i),
    .dbg_wdata_i(dbg_wdata_i), .pend_o(pend_o), .raw_o(raw_o),
    .dbg_rdata_o(dbg_rdata_o)
  );

  typedef struct {
    string      tag;
    logic [W-1:0] pend;
    logic [W-1:0] raw;
    logic [W-1:0] rd;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  logic [W-1:0] m_lat  = '0;
  logic [W-1:0] m_prev = '0;

  task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: compares each result one step after the edge that produced it
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, "pend", pend_o, e.pend);
        check(e.tag, "raw", raw_o, e.raw);
        check(e.tag, "rdata", dbg_rdata_o, e.rd);
      end
    end
  end

  // driver: applies one cycle of stimulus and queues the predicted outputs
  task automatic step(string tag, logic [W-1:0] line, logic [W-1:0] set,
                      logic [W-1:0] clr, logic [W-1:0] act,
                      logic dwr, logic drd, logic dview, logic [W-1:0] dwd);
    exp_t e;
    logic [W-1:0] leff, rise, nxt, setv, clrv;
    @(negedge clk);
    line_i = line; set_stb_i = (set != '0); set_mask_i = set;
    clr_stb_i = (clr != '0); clr_mask_i = clr; act_i = act;
    dbg_wr_i = dwr; dbg_rd_i = drd; dbg_view_i = dview; dbg_wdata_i = dwd;
    leff = line & LVL_OK;
    rise = EDGE & leff & ~m_prev;
    setv = set & VALID;
    clrv = (clr | act) & VALID;
    if (dwr && !dview) nxt = dwd & VALID;
    else               nxt = ((m_lat & ~clrv) | setv | rise) & VALID;
    e.tag  = tag;
    e.rd   = (drd && !dview) ? m_lat : '0;
    e.pend = nxt | (leff & ~EDGE);
    e.raw  = nxt;
    exp_q.push_back(e);
    m_lat  = nxt;
    m_prev = leff;
  endtask

  localparam logic [W-1:0] Z = '0;

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    trig_edge_i = EDGE; line_i = '0; set_stb_i = 0; set_mask_i = '0;
    clr_stb_i = 0; clr_mask_i = '0; act_i = '0; dbg_wr_i = 0; dbg_rd_i = 0;
    dbg_view_i = 0; dbg_wdata_i = '0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "pend in reset", pend_o, Z);
    check("R1", "raw in reset", raw_o, Z);
    @(negedge clk);
    rst = 1'b0;
    step("R1", Z, Z, Z, Z, 0, 1, 0, Z);
    // R2: edge line 16 pulses, then falls, latch stays
    step("R2", 32'h0001_0000, Z, Z, Z, 0, 0, 0, Z);
    step("R2", Z, Z, Z, Z, 0, 0, 0, Z);
    // R2/R3: line 17 held high, cleared, no relatch while held
    step("R2", 32'h0002_0000, Z, Z, Z, 0, 0, 0, Z);
    step("R3", 32'h0002_0000, Z, 32'h0002_0000, Z, 0, 0, 0, Z);
    step("R2", 32'h0002_0000, Z, Z, Z, 0, 0, 0, Z);
    // R3: activation clears edge line 16
    step("R3", Z, Z, Z, 32'h0001_0000, 0, 0, 0, Z);
    // R4: set and clear on bit 18 together, set on level bit 22
    step("R4", Z, 32'h0044_0000, 32'h0004_0000, 32'h0004_0000, 0, 0, 0, Z);
    // R5: level line 23 high, raw unchanged
    step("R5", 32'h0080_0000, Z, Z, Z, 0, 0, 0, Z);
    step("R5", 32'h0080_0000, 32'h0080_0000, Z, Z, 0, 0, 0, Z);
    // R6: clear and activate 22/23 while 23 held high
    step("R6", 32'h0080_0000, Z, 32'h0080_0000, 32'h0040_0000, 0, 0, 0, Z);
    step("R6", Z, Z, Z, Z, 0, 0, 0, Z);
    // R6: latch on level 24 survives the input falling
    step("R6", 32'h0100_0000, 32'h0100_0000, Z, Z, 0, 0, 0, Z);
    step("R6", Z, Z, Z, Z, 0, 0, 0, Z);
    // R7: debug write wins over clear, read returns old latch
    step("R7", Z, Z, 32'hFFFF_FFFF, Z, 1, 1, 0, 32'hFFFF_FFFF);
    step("R7", Z, Z, Z, Z, 0, 1, 0, Z);
    step("R7", Z, Z, Z, Z, 1, 1, 1, 32'h0000_0000);
    step("R7", Z, Z, Z, Z, 1, 0, 0, 32'h0000_0000);
    // R8: sets and lines on non-existent bits 28..31
    step("R8", 32'hF000_0000, 32'hF000_0000, Z, Z, 0, 0, 0, Z);
    step("R8", Z, Z, Z, Z, 0, 1, 0, Z);
    // R9: reserved low line 3 ignores input, takes a set
    step("R9", 32'h0000_0008, Z, Z, Z, 0, 0, 0, Z);
    step("R9", 32'h0000_0008, 32'h0000_0008, Z, Z, 0, 0, 0, Z);
    step("R9", Z, Z, Z, 32'h0000_0008, 0, 0, 0, Z);
    step("R1", Z, Z, Z, Z, 0, 0, 0, Z);
    repeat (3) @(posedge clk);
    #2;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard actual=%0d expected=0 pending items", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule